// File: doc/BRIEF.md
# In-Place Frame Transposition Buffer

This block takes a raster stream of square N×N frames and emits every frame transposed: output line r holds what arrived as input column r. A horizontal filter placed after it can therefore perform vertical smoothing on the stream without any change to the filter. Each output frame is the transpose of the input frame before it, so the output runs exactly one frame behind the input.

All storage is one single-port memory of N² words. For every accepted pixel the block reads the word at one address and then writes the new pixel to that same address. Which address that is depends on the frame. On one frame the pixels are placed in row-major order, and on the next in column-major order. Because of this alternation, the pixels of frame F arrive at the exact words where frame F−1 left its transposed pixels. A second frame store is never needed. In the full-size system the memory is clocked at twice the pixel rate so that the read and the write each get their own access. This model does the read and the write in a single cycle, and the read returns the old contents.

Top module: `frame_transpose_buf`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid`, `out_sol` and `out_sof` are 0 until the first qualified output pixel.
- R2: No output pixel is marked valid during the first frame after reset. A frame starts with an input pixel that has `in_valid`=1 and `in_sof`=1.
- R3: From the second frame after reset onward, every input pixel with `in_valid`=1 yields `out_valid`=1 on the next clock edge, one output per input.
- R4: The output pixel at line r, column c of frame F equals the input pixel at line c, column r of frame F−1. Lines and columns are counted from 0, a line starts at `in_sol`=1 and a frame at `in_sof`=1.
- R5: `out_sol` and `out_sof` repeat `in_sol` and `in_sof` of the same pixel one cycle later, and are only ever 1 together with `out_valid`.
- R6: The storage order changes at every frame start, so the transpose stays correct over three or more frames in a row (frame 0 is stored row-major, frame 1 column-major, and so on).
- R7: A cycle with `in_valid`=0 gives `out_valid`=0 on the next cycle and does not disturb the memory or the line and column position. Idle cycles inside a frame leave the transposed result unchanged.
- R8: `out_pix` keeps its value over cycles that follow an idle input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_sol | input | 1 | Input pixel is first of a line |
| in_sof | input | 1 | Input pixel is first of a frame |
| in_pix | input | DATA_W | Input pixel value |
| out_valid | output | 1 | Output pixel qualifier |
| out_sol | output | 1 | Output pixel is first of a line |
| out_sof | output | 1 | Output pixel is first of a frame |
| out_pix | output | DATA_W | Transposed output pixel |

## Verification
Two instances, with N=4 and N=8, each receive four consecutive full frames. Every pixel value is computed from the frame, line and column numbers, so that a transposed pixel cannot be mistaken for an untransposed one or for a pixel from the wrong frame. Frame 2 is streamed with idle cycles scattered through it. This shows that a gap neither shifts the position count nor corrupts the memory. Frame 3 depends on the storage order having flipped twice, which separates a correct alternation from a fixed order or an order that flips only once.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic {
    ORD_ROW = 1'b0,
    ORD_COL = 1'b1
  } store_order_e;
endpackage

// File: rtl/tp_addr_gen.sv
module tp_addr_gen
  import tp_pkg::*;
#(
  parameter int N = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic          in_sof,
  output logic [$clog2(N*N)-1:0] addr
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam int AW = $clog2(N*N);

  logic [CW-1:0] row_q, col_q, row_d, col_d;
  logic [CW-1:0] cur_r, cur_c;
  store_order_e  ord_q, ord_d, cur_ord;

  // position of the pixel presented this cycle
  always_comb begin
    cur_c   = (in_sof || in_sol) ? '0 : col_q;
    cur_r   = in_sof ? '0 : (in_sol ? row_q + 1'b1 : row_q);
    cur_ord = in_sof ? ((ord_q == ORD_ROW) ? ORD_COL : ORD_ROW) : ord_q;
  end

  always_comb begin
    if (cur_ord == ORD_ROW)
      addr = AW'(cur_r) * AW'(N) + AW'(cur_c);
    else
      addr = AW'(cur_c) * AW'(N) + AW'(cur_r);
  end

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    ord_d = ord_q;
    if (in_valid) begin
      row_d = cur_r;
      col_d = cur_c + 1'b1;
      ord_d = cur_ord;
    end
  end

  // ord_q starts as column order so that the first frame is row-major
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      ord_q <= ORD_COL;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
      ord_q <= ord_d;
    end
  end

  a_r6_order_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (ord_q != $past(ord_q)));

  a_r7_idle_holds_pos: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(row_q) && $stable(col_q) && $stable(ord_q)));
endmodule

// File: rtl/tp_frame_mem.sv
module tp_frame_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  // read returns the old word; the new pixel replaces it at the same address
  always_ff @(posedge clk) begin
    if (en) begin
      rdata       <= store[addr];
      store[addr] <= wdata;
    end
  end

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rdata));
endmodule

// File: rtl/frame_transpose_buf.sv
module frame_transpose_buf #(
  parameter int DATA_W = 8,
  parameter int N      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sol,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_pix,
  output logic              out_valid,
  output logic              out_sol,
  output logic              out_sof,
  output logic [DATA_W-1:0] out_pix
);
  localparam int DEPTH = N * N;
  localparam int AW    = $clog2(DEPTH);

  logic [AW-1:0] addr;
  logic seen_q, seen_d, primed_q, primed_d, primed_now;
  logic v_q, v_d, sol_q, sol_d, sof_q, sof_d;

  tp_addr_gen #(.N(N)) u_addr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_sol(in_sol), .in_sof(in_sof), .addr(addr)
  );

  tp_frame_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .addr(addr),
    .wdata(in_pix), .rdata(out_pix)
  );

  // the memory holds a full frame once the second frame start arrives
  always_comb begin
    primed_now = primed_q | (in_valid & in_sof & seen_q);
    seen_d     = seen_q | (in_valid & in_sof);
    primed_d   = primed_now;
    v_d        = in_valid & primed_now;
    sol_d      = in_valid & primed_now & in_sol;
    sof_d      = in_valid & primed_now & in_sof;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      primed_q <= 1'b0;
      v_q      <= 1'b0;
      sol_q    <= 1'b0;
      sof_q    <= 1'b0;
    end else begin
      seen_q   <= seen_d;
      primed_q <= primed_d;
      v_q      <= v_d;
      sol_q    <= sol_d;
      sof_q    <= sof_d;
    end
  end

  assign out_valid = v_q;
  assign out_sol   = sol_q;
  assign out_sof   = sof_q;

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && primed_q) |=> out_valid);

  a_r7_idle_no_out: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r5_markers_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sol || out_sof) |-> out_valid);

  a_r2_silent_before_second_sof: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && !in_sof) |=> !out_valid);
endmodule

// File: tb/frame_transpose_buf_tb.sv
module frame_transpose_buf_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic       a_v, a_sl, a_sf, b_v, b_sl, b_sf;
  logic [7:0] a_px, b_px;
  logic       a_ov, a_osl, a_osf, b_ov, b_osl, b_osf;
  logic [7:0] a_opx, b_opx;

  frame_transpose_buf #(.DATA_W(8), .N(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(a_v), .in_sol(a_sl), .in_sof(a_sf),
    .in_pix(a_px), .out_valid(a_ov), .out_sol(a_osl), .out_sof(a_osf),
    .out_pix(a_opx)
  );

  frame_transpose_buf #(.DATA_W(8), .N(8)) dut8_i (
    .clk(clk), .rst_n(rst_n), .in_valid(b_v), .in_sol(b_sl), .in_sof(b_sf),
    .in_pix(b_px), .out_valid(b_ov), .out_sol(b_osl), .out_sof(b_osf),
    .out_pix(b_opx)
  );

  function automatic logic [7:0] pv(int f, int r, int c, int n);
    return 8'((f * 61 + r * 17 + c * 5 + n * 3 + 1) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_in(bit big, logic v, logic sl, logic sf, logic [7:0] px);
    if (big) begin b_v = v; b_sl = sl; b_sf = sf; b_px = px; end
    else     begin a_v = v; a_sl = sl; a_sf = sf; a_px = px; end
  endtask

  task automatic idle(bit big);
    logic [7:0] last;
    last = big ? b_opx : a_opx;
    set_in(big, 1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    chk("R7 idle gives no valid", big ? b_ov : a_ov, 0);
    chk("R8 out_pix held", big ? b_opx : a_opx, last);
  endtask

  task automatic run_frame(bit big, int f, bit gaps);
    int n;
    n = big ? 8 : 4;
    for (int r = 0; r < n; r++) begin
      for (int c = 0; c < n; c++) begin
        set_in(big, 1'b1, c == 0, (r == 0) && (c == 0), pv(f, r, c, n));
        @(negedge clk);
        if (f == 0) begin
          chk("R2 first frame silent", big ? b_ov : a_ov, 0);
        end else begin
          chk("R3 valid follows input", big ? b_ov : a_ov, 1);
          chk("R5 sol marker", big ? b_osl : a_osl, c == 0);
          chk("R5 sof marker", big ? b_osf : a_osf, (r == 0) && (c == 0));
          chk(f >= 3 ? "R6 transpose after two flips" : "R4 transpose",
              big ? b_opx : a_opx, pv(f - 1, c, r, n));
        end
        if (gaps && ((r * n + c) % 5 == 2)) idle(big);
      end
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_in(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    set_in(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    chk("R1 reset valid", a_ov, 0);
    chk("R1 reset sof", a_osf | b_osf, 0);
    chk("R1 reset valid N8", b_ov, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", a_ov | b_ov, 0);
    chk("R1 sol after release", a_osl | b_osl, 0);
    for (int k = 0; k < 2; k++) begin
      for (int f = 0; f < 4; f++) begin
        run_frame(k == 1, f, f == 2);
        if (f == 1) idle(k == 1);
      end
      idle(k == 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule